// File: doc/BRIEF.md
# Single-PHY Transmit Packet Receiver

This block sits on the receive side of one transmit port of a point-to-point packet bus that runs in single-PHY mode. The port has its own 8-bit data bus and its own control lines: an active-low enable, a start-of-packet marker, an end-of-packet marker and an error marker. The block qualifies each byte with these lines and passes the packet bytes to a transmit FIFO write port, tagging each one with start, end and error flags. No address cycle exists, and every byte, including the last one, counts as one valid byte.

The block holds the most recently accepted byte for one stage. This lets it close a packet that a new start marker cuts short: the held byte is written with its end and error flags set. Bytes that arrive outside any packet are dropped and reported on a one-cycle framing error pulse. A registered packet-available output tells the sender whether the FIFO still has at least a programmable amount of free space.

Top module: `spf_tx_rx`

## Requirements
- R1: A byte sampled with `tx_en_n` low and `tx_sop` high starts a packet and is written to the FIFO with `fifo_wsop` set.
- R2: Every later byte sampled with `tx_en_n` low is written in arrival order with `fifo_wsop` clear, up to and including the byte sampled with `tx_eop` high, which is written with `fifo_weop` set.
- R3: A cycle with `tx_en_n` high pauses the packet without ending it. Bytes that follow with the enable low again continue the same packet.
- R4: While `tx_en_n` is high, `tx_data`, `tx_sop`, `tx_eop` and `tx_err` have no effect on the FIFO contents or on `frame_err`.
- R5: A byte sampled with `tx_en_n` low and `tx_sop` low while no packet is open is not written. `frame_err` is high for exactly the one cycle after the edge that sampled it.
- R6: A start byte sampled while a packet is still open ends the earlier packet. The last byte written for that packet carries both `fifo_weop` and `fifo_werr`, and the start byte begins a new packet.
- R7: `tx_err` is stored as `fifo_werr` only on the byte sampled with `tx_eop`. A `tx_err` on any other byte is ignored, and `fifo_werr` is never set without `fifo_weop`.
- R8: After each clock edge, `pkt_avail` is high when the `fifo_free` value sampled at that edge is at least `avail_thresh`, and low otherwise.
- R9: While `rst` is high, `fifo_wr`, `frame_err` and `pkt_avail` are low.
- R10: Written entries form whole packets: after reset and after every entry with `fifo_weop`, the next entry written has `fifo_wsop`, and no other entry has it.
- R11: The last byte of a packet appears with `fifo_wr` high in the cycle after the second clock edge that follows the edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_n | input | 1 | Active-low byte enable |
| tx_sop | input | 1 | Start-of-packet marker |
| tx_eop | input | 1 | End-of-packet marker |
| tx_err | input | 1 | Packet error marker, used with end-of-packet |
| tx_data | input | 8 | Data byte |
| fifo_free | input | FREE_W | Free entries reported by the FIFO |
| avail_thresh | input | FREE_W | Free-space threshold for packet-available |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | Byte written |
| fifo_wsop | output | 1 | Written byte starts a packet |
| fifo_weop | output | 1 | Written byte ends a packet |
| fifo_werr | output | 1 | Written packet is errored |
| pkt_avail | output | 1 | Room for more data |
| frame_err | output | 1 | One-cycle pulse for a dropped stray byte |

## Verification
The bench targets a start marker that arrives inside an open packet. A design without the one-byte hold would have no byte left to flag, and the earlier packet would run into the new one with no end. It checks pauses in which markers toggle on the idle bus; a design that decodes markers without the enable would open, close or corrupt packets. It also checks single-byte packets, stray bytes and error markers away from the last byte, where a wrong design would write a stray byte or set an error flag on a middle byte, and it checks the threshold at equality, where an off-by-one comparison gives the wrong availability.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              err;
    } spf_entry_t;

    typedef enum logic [1:0] {
        CLS_IDLE  = 2'd0,
        CLS_START = 2'd1,
        CLS_CONT  = 2'd2,
        CLS_STRAY = 2'd3
    } spf_cls_t;

    function automatic spf_cls_t spf_classify(input logic en_n,
                                              input logic sop,
                                              input logic open_pkt);
        if (en_n)          return CLS_IDLE;
        else if (sop)      return CLS_START;
        else if (open_pkt) return CLS_CONT;
        else               return CLS_STRAY;
    endfunction

endpackage

// File: rtl/spf_framer.sv
module spf_framer
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              sop,
    input  logic              eop,
    input  logic              err,
    input  logic [BYTE_W-1:0] data,
    output logic              st_valid,
    output spf_entry_t        st_entry,
    output logic              st_abort,
    output logic              st_stray
);
    logic     open_pkt;
    spf_cls_t cls;

    always_comb cls = spf_classify(en_n, sop, open_pkt);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_pkt <= 1'b0;
            st_valid <= 1'b0;
            st_abort <= 1'b0;
            st_stray <= 1'b0;
            st_entry <= '0;
        end else begin
            st_valid <= (cls == CLS_START) || (cls == CLS_CONT);
            st_abort <= (cls == CLS_START) && open_pkt;
            st_stray <= (cls == CLS_STRAY);
            st_entry <= '{data: data, sop: (cls == CLS_START),
                          eop: eop, err: eop & err};
            if ((cls == CLS_START) || (cls == CLS_CONT))
                open_pkt <= !eop;
        end
    end
endmodule

// File: rtl/spf_holdback.sv
module spf_holdback
    import spf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_valid,
    input  spf_entry_t st_entry,
    input  logic       st_abort,
    output logic       wr,
    output spf_entry_t wentry
);
    logic       held_v;
    spf_entry_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held   <= '0;
            wr     <= 1'b0;
            wentry <= '0;
        end else begin
            wr <= 1'b0;
            if (st_valid) begin
                if (held_v) begin
                    wr     <= 1'b1;
                    wentry <= held;
                    if (st_abort) begin
                        wentry.eop <= 1'b1;
                        wentry.err <= 1'b1;
                    end
                end
                held   <= st_entry;
                held_v <= 1'b1;
            end else if (held_v && held.eop) begin
                wr     <= 1'b1;
                wentry <= held;
                held_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spf_avail.sv
module spf_avail #(
    parameter int FREE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic [FREE_W-1:0] thresh,
    output logic              avail
);
    always_ff @(posedge clk) begin
        if (rst) avail <= 1'b0;
        else     avail <= (free_cnt >= thresh);
    end
endmodule

// File: rtl/spf_tx_rx.sv
module spf_tx_rx
    import spf_pkg::*;
#(
    parameter int FREE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en_n,
    input  logic              tx_sop,
    input  logic              tx_eop,
    input  logic              tx_err,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic [FREE_W-1:0] avail_thresh,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              fifo_wsop,
    output logic              fifo_weop,
    output logic              fifo_werr,
    output logic              pkt_avail,
    output logic              frame_err
);
    logic       st_valid, st_abort, st_stray;
    spf_entry_t st_entry, wentry;

    spf_framer u_framer (
        .clk(clk), .rst(rst), .en_n(tx_en_n), .sop(tx_sop), .eop(tx_eop),
        .err(tx_err), .data(tx_data), .st_valid(st_valid),
        .st_entry(st_entry), .st_abort(st_abort), .st_stray(st_stray)
    );

    spf_holdback u_hold (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_entry(st_entry),
        .st_abort(st_abort), .wr(fifo_wr), .wentry(wentry)
    );

    spf_avail #(.FREE_W(FREE_W)) u_avail (
        .clk(clk), .rst(rst), .free_cnt(fifo_free), .thresh(avail_thresh),
        .avail(pkt_avail)
    );

    assign frame_err  = st_stray;
    assign fifo_wdata = wentry.data;
    assign fifo_wsop  = wentry.sop;
    assign fifo_weop  = wentry.eop;
    assign fifo_werr  = wentry.err;
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int FREE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_en_n,
    input logic              tx_sop,
    input logic [FREE_W-1:0] fifo_free,
    input logic [FREE_W-1:0] avail_thresh,
    input logic              fifo_wr,
    input logic              fifo_wsop,
    input logic              fifo_weop,
    input logic              fifo_werr,
    input logic              pkt_avail,
    input logic              frame_err
);
    logic seg_open;

    always_ff @(posedge clk) begin
        if (rst)          seg_open <= 1'b0;
        else if (fifo_wr) seg_open <= !fifo_weop;
    end

    p_sop_opens_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !seg_open) |-> fifo_wsop);
    p_no_inner_sop_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && seg_open) |-> !fifo_wsop);
    p_err_on_eop_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_werr) |-> fifo_weop);
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        tx_en_n |=> !frame_err);
    p_sop_not_stray_r5: assert property (@(posedge clk) disable iff (rst)
        tx_sop |=> !frame_err);
    p_avail_low_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_free < avail_thresh) |=> !pkt_avail);
    p_avail_high_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_free >= avail_thresh) |=> pkt_avail);
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!fifo_wr && !frame_err && !pkt_avail));
endmodule

bind spf_tx_rx spf_checker #(.FREE_W(FREE_W)) u_chk (
    .clk(clk), .rst(rst), .tx_en_n(tx_en_n), .tx_sop(tx_sop),
    .fifo_free(fifo_free), .avail_thresh(avail_thresh), .fifo_wr(fifo_wr),
    .fifo_wsop(fifo_wsop), .fifo_weop(fifo_weop), .fifo_werr(fifo_werr),
    .pkt_avail(pkt_avail), .frame_err(frame_err)
);

// File: tb/spf_tx_rx_bench.sv
module spf_tx_rx_bench;
    import spf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FREE_W     = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tx_en_n = 1'b1, tx_sop = 1'b0, tx_eop = 1'b0, tx_err = 1'b0;
    logic [7:0]        tx_data = '0;
    logic [FREE_W-1:0] fifo_free = 10'd100, avail_thresh = 10'd8;
    logic              fifo_wr, fifo_wsop, fifo_weop, fifo_werr, pkt_avail, frame_err;
    logic [7:0]        fifo_wdata;

    int n_chk = 0, n_fail = 0, frm_seen = 0, frm_exp = 0;
    bit m_open = 1'b0, finished = 1'b0;
    spf_entry_t exp_q[$];
    spf_entry_t got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spf_tx_rx #(.FREE_W(FREE_W)) u_spf_tx_rx (
        .clk(clk), .rst(rst), .tx_en_n(tx_en_n), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_err(tx_err), .tx_data(tx_data),
        .fifo_free(fifo_free), .avail_thresh(avail_thresh), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .fifo_wsop(fifo_wsop), .fifo_weop(fifo_weop),
        .fifo_werr(fifo_werr), .pkt_avail(pkt_avail), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst && fifo_wr) got_q.push_back('{fifo_wdata, fifo_wsop, fifo_weop, fifo_werr});
        if (!rst && frame_err) frm_seen++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected FIFO stream, built from the requirements
    task automatic model_step(input bit en_n, input bit sop, input bit eop,
                              input bit err, input logic [7:0] d);
        if (en_n) return;
        if (sop) begin
            if (m_open) begin
                exp_q[exp_q.size()-1].eop = 1'b1;  // R6
                exp_q[exp_q.size()-1].err = 1'b1;
            end
            exp_q.push_back('{d, 1'b1, eop, eop & err});
            m_open = !eop;
        end else if (m_open) begin
            exp_q.push_back('{d, 1'b0, eop, eop & err});
            m_open = !eop;
        end else begin
            frm_exp++;  // R5
        end
    endtask

    task automatic drive(input bit en_n, input bit sop, input bit eop,
                         input bit err, input logic [7:0] d);
        @(negedge clk);
        tx_en_n = en_n; tx_sop = sop; tx_eop = eop; tx_err = err; tx_data = d;
        model_step(en_n, sop, eop, err, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic compare_stream(input string tag);
        chk(got_q.size() == exp_q.size(), {tag, " entry count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], tag, int'(got_q[i]), int'(exp_q[i]));
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed_v;
        seed_v = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(fifo_wr == 1'b0, "R9 fifo_wr in reset", fifo_wr, 0);
        chk(frame_err == 1'b0, "R9 frame_err in reset", frame_err, 0);
        chk(pkt_avail == 1'b0, "R9 pkt_avail in reset", pkt_avail, 0);
        rst = 1'b0;
        idle(3);

        // R1 R2 R3: packet with a pause in the middle
        drive(0, 1, 0, 0, 8'h11);
        drive(0, 0, 0, 0, 8'h22);
        idle(2);
        drive(0, 0, 1, 0, 8'h33);
        idle(4);
        chk(exp_q.size() == 3, "R1 R2 R3 model size", exp_q.size(), 3);
        compare_stream("R1 R2 R3 paused packet");

        // R4: markers toggle while the enable is high inside a packet
        drive(0, 1, 0, 0, 8'hA0);
        drive(1, 1, 1, 1, 8'hFF);
        drive(1, 0, 1, 1, 8'hEE);
        chk(frame_err == 1'b0, "R4 frame_err during pause", frame_err, 0);
        drive(0, 0, 1, 0, 8'hA1);
        idle(4);
        compare_stream("R4 ignored while disabled");

        // R5: stray byte outside any packet
        drive(0, 0, 0, 0, 8'h77);
        drive(1, 0, 0, 0, 8'h00);
        chk(frame_err == 1'b1, "R5 frame_err pulse", frame_err, 1);
        drive(1, 0, 0, 0, 8'h00);
        chk(frame_err == 1'b0, "R5 frame_err one cycle", frame_err, 0);
        idle(3);
        compare_stream("R5 stray dropped");

        // R6: start inside an open packet
        drive(0, 1, 0, 0, 8'hB0);
        drive(0, 0, 0, 0, 8'hB1);
        drive(0, 1, 0, 0, 8'hC0);
        drive(0, 0, 1, 0, 8'hC1);
        idle(4);
        chk(exp_q.size() == 4 && exp_q[1].eop && exp_q[1].err,
            "R6 model abort mark", exp_q.size(), 4);
        compare_stream("R6 aborted packet");

        // R7: error marker on a middle byte and on the last byte
        drive(0, 1, 0, 1, 8'hD0);
        drive(0, 0, 0, 1, 8'hD1);
        drive(0, 0, 1, 1, 8'hD2);
        drive(0, 1, 1, 0, 8'hE0);
        idle(4);
        compare_stream("R7 error with end byte");

        // R11: latency of a single-byte packet
        drive(0, 1, 1, 0, 8'h5A);
        drive(1, 0, 0, 0, 8'h00);
        chk(fifo_wr == 1'b0, "R11 not written after first edge", fifo_wr, 0);
        drive(1, 0, 0, 0, 8'h00);
        chk(fifo_wr == 1'b0, "R11 not written after second edge", fifo_wr, 0);
        drive(1, 0, 0, 0, 8'h00);
        chk(fifo_wr == 1'b1 && fifo_wdata == 8'h5A && fifo_wsop && fifo_weop,
            "R11 written after third edge", fifo_wr, 1);
        idle(2);
        compare_stream("R11 single byte");

        // R8: threshold boundaries
        fifo_free = 10'd5; avail_thresh = 10'd6;
        idle(2);
        chk(pkt_avail == 1'b0, "R8 below threshold", pkt_avail, 0);
        fifo_free = 10'd6;
        idle(2);
        chk(pkt_avail == 1'b1, "R8 equal to threshold", pkt_avail, 1);
        fifo_free = 10'd0; avail_thresh = 10'd0;
        idle(2);
        chk(pkt_avail == 1'b1, "R8 zero threshold", pkt_avail, 1);
        fifo_free = 10'd1023; avail_thresh = 10'd1023;
        idle(2);
        chk(pkt_avail == 1'b1, "R8 full scale", pkt_avail, 1);
        fifo_free = 10'd100; avail_thresh = 10'd8;

        // R10 and all: constrained random traffic
        frm_seen = 0; frm_exp = 0;
        for (int i = 0; i < 3000; i++) begin
            bit en_n, sop, eop, err;
            en_n = ($urandom % 100) < 30;
            sop  = ($urandom % 100) < 12;
            eop  = ($urandom % 100) < 15;
            err  = ($urandom % 100) < 20;
            drive(en_n, sop, eop, err, 8'($urandom));
        end
        if (m_open) drive(0, 0, 1, 0, 8'hCC);
        idle(5);
        chk(frm_seen == frm_exp, "R5 random stray count", frm_seen, frm_exp);
        compare_stream("R10 random stream");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule